// File: doc/BRIEF.md
# Oversampled Polyphase Channelizer

This block divides a stream of complex 8-bit time-domain samples into NCH frequency channels. The channels are evenly spaced and their passbands overlap. A prototype low-pass filter of NCH×TAPS taps is split into NCH polyphase branches. The branch outputs then go through an NCH-point DFT. Each frame consumes DEC new input samples. DEC is smaller than NCH, so every channel is sampled faster than the channel spacing, and by default the rate is 5/4 of the spacing. The DFT input must be rotated by a frame-dependent amount so that channel phase stays coherent from frame to frame. Here that rotation is applied through the twiddle index, and the branch outputs are never moved.

A single complex multiply-accumulate path does all the work in sequence. A frame takes NCH×TAPS cycles of filtering followed by NCH×NCH cycles of DFT. While a frame is being computed, new samples are written into a circular history buffer. That buffer is DEC entries deeper than the filter span, so the window being read is never overwritten. There is no backpressure. If a frame boundary arrives while the engine is still busy, the frame is dropped and a sticky flag is raised. Each output is a 16-bit complex value tagged with its channel number. The rounding constant and the right shift applied to it are set by parameters, and an output that saturates is flagged.

Top module: `chz_channelizer`

## Requirements
- R1: After reset, out_vld_o, out_re_o, out_im_o, out_ovf_o and overrun_o are all zero. The history buffer reads as zero, so samples from before reset count as 0.
- R2: Every DEC accepted input samples form one frame. An accepted frame produces NCH single-cycle out_vld_o pulses, with out_chan_o going 0, 1, …, NCH-1 in ascending order.
- R3: Let n be the index of the newest sample of the frame. Branch r has the value p[r] = Σ_{t<TAPS} h[r+t·NCH]·x[n−r−t·NCH]. The taps are h[i] = round((2^(CW−1)−1)·sin(π(i+0.5)/(NCH·TAPS))), a square-root raised-cosine taper, with rounding half away from zero.
- R4: Frame f (counted from 0 after reset) uses the rotation s = (f·DEC) mod NCH. Bin k is y[k] = Σ_r p[r]·conj(W[(k·((r+s) mod NCH)) mod NCH]). The twiddle is W[e] = C[e] + j·S[e], where C[e] = round(A·cos(2πe/NCH)), S[e] = round(A·sin(2πe/NCH)) and A = 2^(TW−1)−1.
- R5: Each component of the output is (y + 2^(OSH−1)) >>> OSH (arithmetic shift), saturated to the signed OW-bit range. out_ovf_o goes high with the bin whenever either component saturates.
- R6: A frame boundary that occurs while the previous frame is still being computed produces no outputs. It sets overrun_o, which stays high until reset.
- R7: The data inputs are ignored in any cycle where in_vld_i is low. Such cycles change neither the results nor the frame count.
- R8: Bin k of a frame is presented exactly NCH·TAPS + NCH·(k+1) cycles after the clock edge that accepted the frame's last input sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 1 | Input sample valid |
| in_re_i | input | XW | Input real part, signed |
| in_im_i | input | XW | Input imaginary part, signed |
| out_vld_o | output | 1 | Channel sample valid (one-cycle pulse) |
| out_chan_o | output | clog2(NCH) | Channel index of the current output |
| out_re_o | output | OW | Channel real part, signed |
| out_im_o | output | OW | Channel imaginary part, signed |
| out_ovf_o | output | 1 | Current output was saturated |
| overrun_o | output | 1 | Sticky flag: a frame was dropped |

## Verification
The bench records the cycle in which the DEC-th sample of each frame is accepted. Every bin it expects is stamped with a due cycle of that edge plus NCH·TAPS + NCH·(k+1), and each out_vld_o pulse is checked against the head of the queue for its value, its channel, its flag and that exact cycle. Outputs are sampled on the falling edge after the registering edge. The overrun phase drives a frame boundary every 40 cycles against a 140-cycle frame time. From that, exactly every fourth frame must be accepted, so the bench counts pulses only after the engine has had time to drain completely.

// File: rtl/chz_pkg.sv
package chz_pkg;

  typedef enum logic [1:0] {ENG_IDLE, ENG_POLY, ENG_DFT} eng_st_e;

  localparam real PI_R = 3.14159265358979;

  function automatic int rnd_real(input real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

  // sine taper = square root of a raised-cosine window
  function automatic int proto_tap(input int n, input int len, input int w);
    real amp;
    amp = real'((1 << (w - 1)) - 1);
    return rnd_real(amp * $sin(PI_R * (real'(n) + 0.5) / real'(len)));
  endfunction

  function automatic int tw_cos(input int e, input int m, input int w);
    real amp;
    amp = real'((1 << (w - 1)) - 1);
    return rnd_real(amp * $cos(2.0 * PI_R * real'(e) / real'(m)));
  endfunction

  function automatic int tw_sin(input int e, input int m, input int w);
    real amp;
    amp = real'((1 << (w - 1)) - 1);
    return rnd_real(amp * $sin(2.0 * PI_R * real'(e) / real'(m)));
  endfunction

endpackage

// File: rtl/chz_sample_buf.sv
module chz_sample_buf #(
  parameter int XW    = 8,
  parameter int DEPTH = 48
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic signed [XW-1:0]     wr_re_i,
  input  logic signed [XW-1:0]     wr_im_i,
  output logic [$clog2(DEPTH)-1:0] wr_ptr_o,
  input  logic [$clog2(DEPTH)-1:0] rd_addr_i,
  output logic signed [XW-1:0]     rd_re_o,
  output logic signed [XW-1:0]     rd_im_o
);
  localparam int BAW = $clog2(DEPTH);

  logic signed [XW-1:0] mem_re [DEPTH];
  logic signed [XW-1:0] mem_im [DEPTH];
  logic [BAW-1:0]       ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        mem_re[i] <= '0;
        mem_im[i] <= '0;
      end
    end else if (wr_en_i) begin
      mem_re[ptr_q] <= wr_re_i;
      mem_im[ptr_q] <= wr_im_i;
      ptr_q <= (ptr_q == BAW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  assign wr_ptr_o = ptr_q;
  assign rd_re_o  = mem_re[rd_addr_i];
  assign rd_im_o  = mem_im[rd_addr_i];

  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q < BAW'(DEPTH)); // R3

endmodule

// File: rtl/chz_frame_ctl.sv
module chz_frame_ctl #(
  parameter int NCH = 10,
  parameter int DEC = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_vld_i,
  input  logic                   busy_i,
  output logic                   start_o,
  output logic [$clog2(NCH)-1:0] shift_o,
  output logic                   overrun_o
);
  localparam int CNTW = $clog2(DEC);
  localparam int SW   = $clog2(NCH);
  localparam int STEP = DEC % NCH;

  logic [CNTW-1:0] cnt_q;
  logic [SW-1:0]   shift_q;
  logic            ovr_q;
  logic            bound;
  logic [SW:0]     shift_sum;

  assign bound     = in_vld_i && (cnt_q == CNTW'(DEC - 1));
  assign shift_sum = {1'b0, shift_q} + (SW + 1)'(STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shift_q <= '0;
      ovr_q   <= 1'b0;
    end else begin
      if (in_vld_i) cnt_q <= bound ? '0 : cnt_q + 1'b1;
      if (bound) begin
        shift_q <= (shift_sum >= (SW + 1)'(NCH)) ? SW'(shift_sum - (SW + 1)'(NCH))
                                                 : shift_sum[SW-1:0];
        if (busy_i) ovr_q <= 1'b1;
      end
    end
  end

  assign start_o   = bound && !busy_i;
  assign shift_o   = shift_q;
  assign overrun_o = ovr_q;

  AST_OVERRUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |=> ovr_q); // R6
  AST_SHIFT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_q < SW'(NCH)); // R4

endmodule

// File: rtl/chz_rom.sv
module chz_rom #(
  parameter int NCH  = 10,
  parameter int TAPS = 4,
  parameter int CW   = 12,
  parameter int TW   = 12
) (
  input  logic [$clog2(NCH*TAPS)-1:0] tap_idx_i,
  output logic signed [CW-1:0]        tap_o,
  input  logic [$clog2(NCH)-1:0]      tw_idx_i,
  output logic signed [TW-1:0]        cos_o,
  output logic signed [TW-1:0]        sin_o
);
  localparam int L = NCH * TAPS;

  logic signed [CW-1:0] tap_tbl [L];
  logic signed [TW-1:0] cos_tbl [NCH];
  logic signed [TW-1:0] sin_tbl [NCH];

  for (genvar g = 0; g < L; g++) begin : g_tap
    assign tap_tbl[g] = CW'(chz_pkg::proto_tap(g, L, CW));
  end

  for (genvar g = 0; g < NCH; g++) begin : g_tw
    assign cos_tbl[g] = TW'(chz_pkg::tw_cos(g, NCH, TW));
    assign sin_tbl[g] = TW'(chz_pkg::tw_sin(g, NCH, TW));
  end

  assign tap_o = tap_tbl[tap_idx_i];
  assign cos_o = cos_tbl[tw_idx_i];
  assign sin_o = sin_tbl[tw_idx_i];

endmodule

// File: rtl/chz_engine.sv
module chz_engine
  import chz_pkg::*;
#(
  parameter int NCH   = 10,
  parameter int TAPS  = 4,
  parameter int XW    = 8,
  parameter int CW    = 12,
  parameter int TW    = 12,
  parameter int OW    = 16,
  parameter int OSH   = 18,
  parameter int DEPTH = 48
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [$clog2(DEPTH)-1:0]    base_i,
  input  logic [$clog2(NCH)-1:0]      shift_i,
  output logic                        busy_o,
  output logic [$clog2(DEPTH)-1:0]    rd_addr_o,
  input  logic signed [XW-1:0]        smp_re_i,
  input  logic signed [XW-1:0]        smp_im_i,
  output logic [$clog2(NCH*TAPS)-1:0] tap_idx_o,
  input  logic signed [CW-1:0]        tap_i,
  output logic [$clog2(NCH)-1:0]      tw_idx_o,
  input  logic signed [TW-1:0]        cos_i,
  input  logic signed [TW-1:0]        sin_i,
  output logic                        vld_o,
  output logic [$clog2(NCH)-1:0]      chan_o,
  output logic signed [OW-1:0]        re_o,
  output logic signed [OW-1:0]        im_o,
  output logic                        ovf_o
);
  localparam int L   = NCH * TAPS;
  localparam int RW  = $clog2(NCH);
  localparam int TCW = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int JW  = $clog2(L);
  localparam int BAW = $clog2(DEPTH);
  localparam int PW  = XW + CW + TCW;
  localparam int MW  = PW + TW + 1;
  localparam int AW  = MW + $clog2(NCH);
  localparam logic signed [AW-1:0] RND = 1 <<< (OSH - 1);
  localparam logic signed [AW-1:0] HI  = (1 <<< (OW - 1)) - 1;
  localparam logic signed [AW-1:0] LO  = -HI - 1;

  eng_st_e st_q;
  logic [RW-1:0]  r_q, k_q, e_q, ek0_q, s_q, chan_q, chan_prev_q;
  logic [TCW-1:0] t_q;
  logic [BAW-1:0] base_q;
  logic signed [PW-1:0] pacc_re_q, pacc_im_q;
  logic signed [PW-1:0] pb_re_q [NCH];
  logic signed [PW-1:0] pb_im_q [NCH];
  logic signed [AW-1:0] acc_re_q, acc_im_q;
  logic signed [OW-1:0] re_q, im_q;
  logic vld_q, ovf_q;

  function automatic logic [RW-1:0] madd(input logic [RW-1:0] a, input logic [RW-1:0] b);
    logic [RW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s >= (RW + 1)'(NCH)) ? RW'(s - (RW + 1)'(NCH)) : s[RW-1:0];
  endfunction

  // {saturated, value}
  function automatic logic [OW:0] sat_fn(input logic signed [AW-1:0] a);
    logic signed [AW-1:0] sh;
    sh = (a + RND) >>> OSH;
    if (sh > HI) return {1'b1, HI[OW-1:0]};
    if (sh < LO) return {1'b1, LO[OW-1:0]};
    return {1'b0, sh[OW-1:0]};
  endfunction

  // polyphase address path
  logic [JW-1:0]  j_w;
  logic [BAW:0]   ra_sum;
  assign j_w    = JW'(r_q) + JW'(t_q) * JW'(NCH);
  assign ra_sum = {1'b0, base_q} + (BAW + 1)'(DEPTH) - (BAW + 1)'(j_w);
  assign rd_addr_o = (ra_sum >= (BAW + 1)'(DEPTH)) ? BAW'(ra_sum - (BAW + 1)'(DEPTH))
                                                   : ra_sum[BAW-1:0];
  assign tap_idx_o = j_w;
  assign tw_idx_o  = e_q;

  // filter MAC
  logic signed [XW+CW-1:0] pm_re, pm_im;
  logic signed [PW-1:0]    pbase_re, pbase_im, pnx_re, pnx_im;
  assign pm_re    = smp_re_i * tap_i;
  assign pm_im    = smp_im_i * tap_i;
  assign pbase_re = (t_q == '0) ? '0 : pacc_re_q;
  assign pbase_im = (t_q == '0) ? '0 : pacc_im_q;
  assign pnx_re   = pbase_re + pm_re;
  assign pnx_im   = pbase_im + pm_im;

  // DFT MAC: p * conj(W)
  logic signed [PW-1:0] pr_w, pi_w;
  logic signed [MW-1:0] cm_re, cm_im;
  logic signed [AW-1:0] abase_re, abase_im, anx_re, anx_im;
  assign pr_w     = pb_re_q[r_q];
  assign pi_w     = pb_im_q[r_q];
  assign cm_re    = pr_w * cos_i + pi_w * sin_i;
  assign cm_im    = pi_w * cos_i - pr_w * sin_i;
  assign abase_re = (r_q == '0) ? '0 : acc_re_q;
  assign abase_im = (r_q == '0) ? '0 : acc_im_q;
  assign anx_re   = abase_re + cm_re;
  assign anx_im   = abase_im + cm_im;

  logic [OW:0] sr, si;
  assign sr = sat_fn(anx_re);
  assign si = sat_fn(anx_im);

  logic r_last, t_last, k_last;
  assign r_last = (r_q == RW'(NCH - 1));
  assign t_last = (t_q == TCW'(TAPS - 1));
  assign k_last = (k_q == RW'(NCH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ENG_IDLE;
      r_q       <= '0;
      t_q       <= '0;
      k_q       <= '0;
      e_q       <= '0;
      ek0_q     <= '0;
      s_q       <= '0;
      base_q    <= '0;
      pacc_re_q <= '0;
      pacc_im_q <= '0;
      acc_re_q  <= '0;
      acc_im_q  <= '0;
      vld_q     <= 1'b0;
      chan_q    <= '0;
      re_q      <= '0;
      im_q      <= '0;
      ovf_q     <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        pb_re_q[i] <= '0;
        pb_im_q[i] <= '0;
      end
    end else begin
      vld_q <= 1'b0;
      unique case (st_q)
        ENG_IDLE: begin
          if (start_i) begin
            base_q <= base_i;
            s_q    <= shift_i;
            r_q    <= '0;
            t_q    <= '0;
            st_q   <= ENG_POLY;
          end
        end
        ENG_POLY: begin
          pacc_re_q <= pnx_re;
          pacc_im_q <= pnx_im;
          if (t_last) begin
            pb_re_q[r_q] <= pnx_re;
            pb_im_q[r_q] <= pnx_im;
            t_q <= '0;
            if (r_last) begin
              r_q   <= '0;
              k_q   <= '0;
              e_q   <= '0;
              ek0_q <= '0;
              st_q  <= ENG_DFT;
            end else begin
              r_q <= r_q + 1'b1;
            end
          end else begin
            t_q <= t_q + 1'b1;
          end
        end
        ENG_DFT: begin
          acc_re_q <= anx_re;
          acc_im_q <= anx_im;
          if (r_last) begin
            vld_q  <= 1'b1;
            chan_q <= k_q;
            re_q   <= sr[OW-1:0];
            im_q   <= si[OW-1:0];
            ovf_q  <= sr[OW] | si[OW];
            r_q    <= '0;
            ek0_q  <= madd(ek0_q, s_q);
            e_q    <= madd(ek0_q, s_q);
            if (k_last) st_q <= ENG_IDLE;
            else        k_q  <= k_q + 1'b1;
          end else begin
            r_q <= r_q + 1'b1;
            e_q <= madd(e_q, k_q);
          end
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    chan_prev_q <= '0;
    else if (vld_q) chan_prev_q <= chan_q;
  end

  assign busy_o = (st_q != ENG_IDLE);
  assign vld_o  = vld_q;
  assign chan_o = chan_q;
  assign re_o   = re_q;
  assign im_o   = im_q;
  assign ovf_o  = ovf_q;

  AST_CHAN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> chan_q < RW'(NCH)); // R2
  AST_CHAN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && chan_q != '0) |-> chan_prev_q == RW'(chan_q - 1'b1)); // R2
  AST_SAT_RAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> (re_q == HI[OW-1:0] || re_q == LO[OW-1:0] ||
               im_q == HI[OW-1:0] || im_q == LO[OW-1:0])); // R5
  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && st_q == ENG_IDLE) |=> st_q == ENG_POLY); // R8

endmodule

// File: rtl/chz_channelizer.sv
module chz_channelizer #(
  parameter int NCH  = 10,
  parameter int DEC  = 8,
  parameter int TAPS = 4,
  parameter int XW   = 8,
  parameter int CW   = 12,
  parameter int TW   = 12,
  parameter int OW   = 16,
  parameter int OSH  = 18
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_vld_i,
  input  logic signed [XW-1:0]   in_re_i,
  input  logic signed [XW-1:0]   in_im_i,
  output logic                   out_vld_o,
  output logic [$clog2(NCH)-1:0] out_chan_o,
  output logic signed [OW-1:0]   out_re_o,
  output logic signed [OW-1:0]   out_im_o,
  output logic                   out_ovf_o,
  output logic                   overrun_o
);
  localparam int L     = NCH * TAPS;
  localparam int DEPTH = L + DEC;
  localparam int BAW   = $clog2(DEPTH);
  localparam int RW    = $clog2(NCH);
  localparam int JW    = $clog2(L);

  logic                 start, busy;
  logic [RW-1:0]        shift, tw_idx;
  logic [BAW-1:0]       wr_ptr, rd_addr;
  logic signed [XW-1:0] smp_re, smp_im;
  logic [JW-1:0]        tap_idx;
  logic signed [CW-1:0] tap;
  logic signed [TW-1:0] tw_cos, tw_sin;

  chz_sample_buf #(.XW(XW), .DEPTH(DEPTH)) u_buf (
    .clk_i, .rst_ni,
    .wr_en_i  (in_vld_i),
    .wr_re_i  (in_re_i),
    .wr_im_i  (in_im_i),
    .wr_ptr_o (wr_ptr),
    .rd_addr_i(rd_addr),
    .rd_re_o  (smp_re),
    .rd_im_o  (smp_im)
  );

  chz_frame_ctl #(.NCH(NCH), .DEC(DEC)) u_ctl (
    .clk_i, .rst_ni,
    .in_vld_i,
    .busy_i   (busy),
    .start_o  (start),
    .shift_o  (shift),
    .overrun_o
  );

  chz_rom #(.NCH(NCH), .TAPS(TAPS), .CW(CW), .TW(TW)) u_rom (
    .tap_idx_i(tap_idx),
    .tap_o    (tap),
    .tw_idx_i (tw_idx),
    .cos_o    (tw_cos),
    .sin_o    (tw_sin)
  );

  chz_engine #(
    .NCH(NCH), .TAPS(TAPS), .XW(XW), .CW(CW), .TW(TW),
    .OW(OW), .OSH(OSH), .DEPTH(DEPTH)
  ) u_eng (
    .clk_i, .rst_ni,
    .start_i  (start),
    .base_i   (wr_ptr),
    .shift_i  (shift),
    .busy_o   (busy),
    .rd_addr_o(rd_addr),
    .smp_re_i (smp_re),
    .smp_im_i (smp_im),
    .tap_idx_o(tap_idx),
    .tap_i    (tap),
    .tw_idx_o (tw_idx),
    .cos_i    (tw_cos),
    .sin_i    (tw_sin),
    .vld_o    (out_vld_o),
    .chan_o   (out_chan_o),
    .re_o     (out_re_o),
    .im_o     (out_im_o),
    .ovf_o    (out_ovf_o)
  );

endmodule

// File: tb/chz_channelizer_tb_top.sv
module chz_channelizer_tb_top;
  localparam int NCH = 10, DEC = 8, TAPS = 4, XW = 8, CW = 12, TW = 12, OW = 16, OSH = 18;
  localparam int L = NCH * TAPS;
  localparam real PI_B = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic signed [XW-1:0] in_re = '0, in_im = '0;
  logic out_vld, out_ovf, overrun;
  logic [$clog2(NCH)-1:0] out_chan;
  logic signed [OW-1:0] out_re, out_im;

  always #5 clk = ~clk;

  chz_channelizer #(.NCH(NCH), .DEC(DEC), .TAPS(TAPS), .XW(XW), .CW(CW),
                    .TW(TW), .OW(OW), .OSH(OSH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_vld_i(in_vld), .in_re_i(in_re), .in_im_i(in_im),
    .out_vld_o(out_vld), .out_chan_o(out_chan), .out_re_o(out_re), .out_im_o(out_im),
    .out_ovf_o(out_ovf), .overrun_o(overrun));

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;
  bit done = 0, model_on = 1;
  int out_cnt = 0;

  longint hre[1024], him[1024];
  int nsamp = 0, nframe = 0;
  longint q_re[$], q_im[$], q_due[$];
  int q_ch[$];
  bit q_ov[$];
  int n_ovf_exp = 0;
  int tap_b[L], cw_b[NCH], sw_b[NCH];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int rnd_b(real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic longint rsat(longint a, output bit ov);
    longint v, hi, lo;
    hi = (64'sd1 <<< (OW - 1)) - 1;
    lo = -hi - 1;
    v = (a + (64'sd1 <<< (OSH - 1))) >>> OSH;
    ov = 0;
    if (v > hi) begin v = hi; ov = 1; end
    if (v < lo) begin v = lo; ov = 1; end
    return v;
  endfunction

  // R3/R4/R5 reference for the frame just completed
  task automatic push_frame(longint trig);
    longint pr[NCH], pi[NCH];
    int s;
    s = (nframe * DEC) % NCH;
    for (int r = 0; r < NCH; r++) begin
      pr[r] = 0; pi[r] = 0;
      for (int t = 0; t < TAPS; t++) begin
        int idx;
        idx = nsamp - 1 - r - t * NCH;
        if (idx >= 0) begin
          pr[r] += longint'(tap_b[r + t * NCH]) * hre[idx];
          pi[r] += longint'(tap_b[r + t * NCH]) * him[idx];
        end
      end
    end
    for (int k = 0; k < NCH; k++) begin
      longint ar, ai;
      bit o1, o2;
      ar = 0; ai = 0;
      for (int r = 0; r < NCH; r++) begin
        int e;
        e = (k * ((r + s) % NCH)) % NCH;
        ar += pr[r] * cw_b[e] + pi[r] * sw_b[e];
        ai += pi[r] * cw_b[e] - pr[r] * sw_b[e];
      end
      q_re.push_back(rsat(ar, o1));
      q_im.push_back(rsat(ai, o2));
      q_ov.push_back(o1 | o2);
      if (o1 | o2) n_ovf_exp++;
      q_ch.push_back(k);
      q_due.push_back(trig + NCH * TAPS + NCH * (k + 1));
    end
    nframe++;
  endtask

  task automatic send(int re, int im, int gap);
    @(negedge clk);
    in_vld = 1'b1; in_re = XW'(re); in_im = XW'(im);
    @(negedge clk);
    in_vld = 1'b0;
    in_re = XW'($urandom); in_im = XW'($urandom);  // R7: junk while invalid
    if (model_on) begin
      hre[nsamp] = re; him[nsamp] = im;
      nsamp++;
      if (nsamp % DEC == 0) push_frame(cyc);
    end
    repeat (gap - 2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      out_cnt++;
      if (model_on) begin
        if (q_re.size() == 0) chk(0, "R2 unexpected output chan", out_chan, -1);
        else begin
          longint er, ei, ed; int ec; bit eo;
          er = q_re.pop_front(); ei = q_im.pop_front(); ed = q_due.pop_front();
          ec = q_ch.pop_front(); eo = q_ov.pop_front();
          chk(out_chan == ec, "R2 chan", out_chan, ec);
          chk(out_re == er, eo ? "R5 re" : "R4 re", out_re, er);
          chk(out_im == ei, eo ? "R5 im" : "R4 im", out_im, ei);
          chk(out_ovf == eo, "R5 ovf", out_ovf, eo);
          chk(cyc == ed, "R8 timing", cyc, ed);
        end
      end
    end
  end

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=%0d exp=0", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int base_cnt;
    void'($urandom(32'd1234));
    for (int i = 0; i < L; i++) tap_b[i] = rnd_b(2047.0 * $sin(PI_B * (real'(i) + 0.5) / real'(L)));
    for (int e = 0; e < NCH; e++) begin
      cw_b[e] = rnd_b(2047.0 * $cos(2.0 * PI_B * real'(e) / real'(NCH)));
      sw_b[e] = rnd_b(2047.0 * $sin(2.0 * PI_B * real'(e) / real'(NCH)));
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(out_vld == 0, "R1 vld", out_vld, 0);
    chk(out_re == 0 && out_im == 0, "R1 data", out_re, 0);
    chk(out_ovf == 0, "R1 ovf", out_ovf, 0);
    chk(overrun == 0, "R1 overrun", overrun, 0);

    // R3: impulse through the taps
    send(127, -64, 20);
    for (int i = 1; i < 48; i++) send(0, 0, 20);
    // R3/R4: random samples
    for (int i = 0; i < 80; i++) send($urandom_range(255) - 128, $urandom_range(255) - 128, 20);
    // R5: full-scale DC drives bin 0 into saturation
    for (int i = 0; i < 32; i++) send(127, -128, 20);
    for (int i = 0; i < 32; i++) send(-128, 127, 20);
    repeat (200) @(negedge clk);
    chk(q_re.size() == 0, "R2 frames outstanding", q_re.size(), 0);
    chk(n_ovf_exp > 0, "R5 saturation exercised", n_ovf_exp, 1);

    // R7: long invalid stretch with changing data yields nothing
    base_cnt = out_cnt;
    repeat (200) begin
      @(negedge clk);
      in_re = XW'($urandom); in_im = XW'($urandom);
    end
    chk(out_cnt == base_cnt, "R7 no output while invalid", out_cnt - base_cnt, 0);
    chk(overrun == 0, "R6 no overrun at legal rate", overrun, 0);

    // R6: frame boundary every 40 cycles, frame takes 140
    model_on = 0;
    base_cnt = out_cnt;
    for (int i = 0; i < 16 * DEC; i++) send($urandom_range(255) - 128, 0, 5);
    repeat (300) @(negedge clk);
    chk(overrun == 1, "R6 overrun set", overrun, 1);
    chk(out_cnt - base_cnt == 4 * NCH, "R6 dropped frames", out_cnt - base_cnt, 4 * NCH);
    repeat (100) @(negedge clk);
    chk(overrun == 1, "R6 overrun sticky", overrun, 1);

    // R1: reset clears flag and restarts the frame count
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(overrun == 0, "R1 overrun cleared", overrun, 0);
    rst_n = 1'b1;
    nsamp = 0; nframe = 0; model_on = 1;
    q_re.delete(); q_im.delete(); q_due.delete(); q_ch.delete(); q_ov.delete();
    for (int i = 0; i < 40; i++) send($urandom_range(255) - 128, $urandom_range(255) - 128, 18);
    repeat (200) @(negedge clk);
    chk(q_re.size() == 0, "R2 frames outstanding after reset", q_re.size(), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule